// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns 32-bit virtual addresses into 30-bit physical addresses for a paged memory with 4 KB pages. A requester presents a virtual address together with an access kind (read or write). The block first looks the page up in a small fully associative translation cache. On a miss it computes the location of the page table entry from a writable base register, which selects the active per-process table, and reads that entry through a simple memory read port. The requester then receives either a physical address or a fault code.

A page table entry carries a presence flag, a read permission flag, a write permission flag and a physical page number. A missing page and a forbidden access are reported as two different fault codes so that software can tell them apart. Software handles faults and chooses frames; the block only translates and checks permissions. Writing the base register or pulsing the flush input empties the cache, so no stale translation outlives a change of address space.

Top module: `page_xlate`

## Requirements
- R1: A permitted access to a present page responds with fault code 0 and a physical address equal to entry bits 17:0 (physical page number) placed above virtual address bits 11:0, which pass through unchanged. For example, page number 0x020C0 with offset 0x0F3 gives 0x020C00F3.
- R2: On a cache miss, exactly one memory read is issued, for one cycle, at address base + 4 × (virtual address bits 31:12).
- R3: If entry bit 31 (present) is 0, the response carries fault code 1 and a physical address of zero, and the entry is not cached, so the next access to that page reads memory again.
- R4: If entry bit 30 (read allowed) is 0, or the access is a write and entry bit 29 (write allowed) is 0, the response carries fault code 2 and a physical address of zero. A present entry is cached even when it faults this way.
- R5: A request that hits in the cache issues no memory read and responds in the cycle after it is accepted.
- R6: A request that misses responds in the cycle after the cycle in which read data valid is high.
- R7: Writing the base register invalidates every cached translation, so the next request walks the new table.
- R8: A one-cycle pulse on the flush input invalidates every cached translation.
- R9: The cache holds 8 translations and replaces them in round-robin order. After 8 distinct pages are filled, a ninth evicts the oldest fill, and the other pages still hit.
- R10: Only one request is outstanding at a time. Ready is low from acceptance through the response cycle, and response valid is a single-cycle pulse.
- R11: After reset, ready is high, response valid and memory read request are low, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| baseWrEn | input | 1 | Write strobe for the table base register |
| baseWrData | input | 32 | New table base (byte address) |
| flush | input | 1 | Invalidate all cached translations |
| memReqValid | output | 1 | Page table entry read request |
| memAddr | output | 32 | Byte address of the entry |
| memRdValid | input | 1 | Entry read data valid |
| memRdData | input | 32 | Entry read data |
| rspValid | output | 1 | Response valid (one cycle) |
| rspPaddr | output | 30 | Physical address, zero on a fault |
| rspFault | output | 2 | 0 = none, 1 = page absent, 2 = permission denied |

## Verification
The hardest state to reach from the ports is a full cache whose round-robin pointer has wrapped. Only the pointer decides which translation the ninth fill evicts, and the pointer is hidden. The stimulus flushes the cache and then fills eight distinct present pages from a second table. It then touches a ninth page and shows the eviction indirectly: a surviving page still hits with no memory read and one-cycle latency, while the oldest page walks again. Cycle-accurate latency and a count of memory reads separate hits from walks throughout.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int PTE_PRESENT = 31;
  localparam int PTE_RD      = 30;
  localparam int PTE_WR      = 29;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } xlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic loadHit;
    logic loadWalk;
  } xlStrobe_t;

  function automatic fault_e judgeAccess(input logic present, input logic rdOk,
                                         input logic wrOk, input logic isWrite);
    if (!present)                  return FLT_PAGE;
    else if (!rdOk)                return FLT_PROT;
    else if (isWrite && !wrOk)     return FLT_PROT;
    else                           return FLT_NONE;
  endfunction

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      lookupHit,
  input  logic      memRdValid,
  output logic      reqReady,
  output logic      memReqValid,
  output logic      rspValid,
  output logic      walkBusy,
  output xlStrobe_t strobe
);

  xlState_e state, stateNext;
  logic accept;

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);
  assign rspValid    = (state == ST_DONE);
  assign walkBusy    = (state == ST_ISSUE) || (state == ST_WAIT);
  assign accept      = reqValid && reqReady;

  always_comb begin
    strobe.captureReq = accept;
    strobe.loadHit    = accept && lookupHit;
    strobe.loadWalk   = (state == ST_WAIT) && memRdValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (accept) stateNext = lookupHit ? ST_DONE : ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT:  if (memRdValid) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 18,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xlStrobe_t              strobe,
  input  logic [VA_W-1:0]        reqVaddr,
  input  logic                   reqWrite,
  input  logic                   baseWrEn,
  input  logic [VA_W-1:0]        baseWrData,
  input  logic                   flush,
  input  logic [31:0]            memRdData,
  output logic                   lookupHit,
  output logic [VA_W-1:0]        memAddr,
  output logic [PPN_W+OFF_W-1:0] rspPaddr,
  output logic [1:0]             rspFault
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [VA_W-1:0]  baseQ;
  logic [VPN_W-1:0] vpnQ;
  logic [OFF_W-1:0] offQ;
  logic             writeQ;

  logic [ENTRIES-1:0] lineValid, lineRd, lineWr, matchVec;
  logic [VPN_W-1:0]   lineVpn [ENTRIES];
  logic [PPN_W-1:0]   linePpn [ENTRIES];
  logic [IDX_W-1:0]   rrPtr;

  logic [VPN_W-1:0] reqVpn;
  logic [PPN_W-1:0] hitPpn;
  logic             hitRd, hitWr;
  logic             doFill, wipe;
  fault_e           hitFault, walkFault;

  assign reqVpn = reqVaddr[VA_W-1:OFF_W];

  // parallel tag compare
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = lineValid[g] && (lineVpn[g] == reqVpn);
  end

  assign lookupHit = |matchVec;

  always_comb begin
    hitPpn = '0;
    hitRd  = 1'b0;
    hitWr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        hitPpn = hitPpn | linePpn[i];
        hitRd  = hitRd  | lineRd[i];
        hitWr  = hitWr  | lineWr[i];
      end
    end
  end

  assign hitFault  = judgeAccess(1'b1, hitRd, hitWr, reqWrite);
  assign walkFault = judgeAccess(memRdData[PTE_PRESENT], memRdData[PTE_RD],
                                 memRdData[PTE_WR], writeQ);

  assign wipe   = flush || baseWrEn;
  assign doFill = strobe.loadWalk && memRdData[PTE_PRESENT] && !wipe;

  // entry address: base plus page number scaled to 4-byte entries
  assign memAddr = baseQ + VA_W'({vpnQ, 2'b00});

  always_ff @(posedge clk) begin
    if (!rstN) baseQ <= '0;
    else if (baseWrEn) baseQ <= baseWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ   <= '0;
      offQ   <= '0;
      writeQ <= 1'b0;
    end else if (strobe.captureReq) begin
      vpnQ   <= reqVpn;
      offQ   <= reqVaddr[OFF_W-1:0];
      writeQ <= reqWrite;
    end
  end

  // valid bits and replacement pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
      rrPtr     <= '0;
    end else if (wipe) begin
      lineValid <= '0;
    end else if (doFill) begin
      lineValid[rrPtr] <= 1'b1;
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  // line payload, no reset needed
  always_ff @(posedge clk) begin
    if (doFill) begin
      lineVpn[rrPtr] <= vpnQ;
      linePpn[rrPtr] <= memRdData[PPN_W-1:0];
      lineRd[rrPtr]  <= memRdData[PTE_RD];
      lineWr[rrPtr]  <= memRdData[PTE_WR];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
      rspFault <= FLT_NONE;
    end else if (strobe.loadHit) begin
      rspFault <= hitFault;
      rspPaddr <= (hitFault == FLT_NONE) ? {hitPpn, reqVaddr[OFF_W-1:0]} : PA_W'(0);
    end else if (strobe.loadWalk) begin
      rspFault <= walkFault;
      rspPaddr <= (walkFault == FLT_NONE) ? {memRdData[PPN_W-1:0], offQ} : PA_W'(0);
    end
  end

endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 18,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [VA_W-1:0]        reqVaddr,
  input  logic                   reqWrite,
  input  logic                   baseWrEn,
  input  logic [VA_W-1:0]        baseWrData,
  input  logic                   flush,
  output logic                   memReqValid,
  output logic [VA_W-1:0]        memAddr,
  input  logic                   memRdValid,
  input  logic [31:0]            memRdData,
  output logic                   rspValid,
  output logic [PPN_W+OFF_W-1:0] rspPaddr,
  output logic [1:0]             rspFault
);

  xlStrobe_t strobe;
  logic      lookupHit;
  logic      walkBusy;

  xlate_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .lookupHit  (lookupHit),
    .memRdValid (memRdValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .rspValid   (rspValid),
    .walkBusy   (walkBusy),
    .strobe     (strobe)
  );

  xlate_dp #(
    .VA_W   (VA_W),
    .OFF_W  (OFF_W),
    .PPN_W  (PPN_W),
    .ENTRIES(ENTRIES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .flush      (flush),
    .memRdData  (memRdData),
    .lookupHit  (lookupHit),
    .memAddr    (memAddr),
    .rspPaddr   (rspPaddr),
    .rspFault   (rspFault)
  );

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            memReqValid,
  input logic            memRdValid,
  input logic            rspValid,
  input logic [PA_W-1:0] rspPaddr,
  input logic [1:0]      rspFault,
  input logic            walkBusy
);

  // R3 / R4: a faulting response never carries an address
  assert_fault_nopa_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> rspPaddr == '0);

  // R4: only the three defined codes appear
  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspFault != 2'd3);

  // R2: a walk issues a single-cycle read
  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R10: acceptance closes the door until the response is gone
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: response is a pulse, then ready returns
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R6: read data during a walk yields a response next cycle
  assert_walk_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (walkBusy && !memReqValid && memRdValid) |=> rspValid);

endmodule

bind page_xlate xlate_chk #(.PA_W(PPN_W + OFF_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memReqValid(memReqValid),
  .memRdValid (memRdValid),
  .rspValid   (rspValid),
  .rspPaddr   (rspPaddr),
  .rspFault   (rspFault),
  .walkBusy   (walkBusy)
);

// File: tb/page_xlate_tb_top.sv
module page_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        flush = 1'b0;
  logic        memReqValid;
  logic [31:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        rspValid;
  logic [29:0] rspPaddr;
  logic [1:0]  rspFault;

  int total = 0;
  int bad = 0;
  int reads = 0;
  logic [31:0] lastAddr = '0;
  logic [31:0] curBase = '0;
  logic [31:0] ptMem [256];

  always #2.5 clk = ~clk;

  page_xlate dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .flush(flush), .memReqValid(memReqValid),
    .memAddr(memAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault)
  );

  // memory model: data two edges after the request is seen
  initial begin
    forever begin
      @(posedge clk);
      if (memReqValid) begin
        lastAddr = memAddr;
        reads++;
        repeat (2) @(posedge clk);
        #1;
        memRdData  = ptMem[lastAddr[9:2]];
        memRdValid = 1'b1;
        @(posedge clk);
        #1;
        memRdValid = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: expected address and code from the bench table
  task automatic expect_of(input logic [31:0] va, input bit wr,
                           output logic [29:0] pa, output logic [1:0] flt);
    logic [31:0] pte;
    pte = ptMem[8'((curBase >> 2) + 32'(va[31:12]))];
    if (!pte[31])                   flt = 2'd1;
    else if (!pte[30])              flt = 2'd2;
    else if (wr && !pte[29])        flt = 2'd2;
    else                            flt = 2'd0;
    pa = (flt == 2'd0) ? {pte[17:0], va[11:0]} : 30'd0;
  endtask

  task automatic runReq(input logic [31:0] va, input bit wr,
                        output int lat, output logic [29:0] pa, output logic [1:0] flt);
    while (!reqReady) @(negedge clk);
    reqVaddr = va;
    reqWrite = wr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    pa  = rspPaddr;
    flt = rspFault;
    chk("R10 ready low during response", 64'(reqReady), 64'(0));
  endtask

  // one full checked translation
  task automatic xlate(input string tag, input logic [31:0] va, input bit wr,
                       input int expLat, input int expReads);
    int lat, r0;
    logic [29:0] pa, ePa;
    logic [1:0] flt, eFlt;
    r0 = reads;
    expect_of(va, wr, ePa, eFlt);
    runReq(va, wr, lat, pa, flt);
    chk({tag, " paddr"}, 64'(pa), 64'(ePa));
    chk({tag, " fault"}, 64'(flt), 64'(eFlt));
    chk({tag, " latency"}, 64'(lat), 64'(expLat));
    chk({tag, " reads"}, 64'(reads - r0), 64'(expReads));
  endtask

  task automatic test_reset;
    chk("R11 ready after reset", 64'(reqReady), 64'(1));
    chk("R11 rspValid after reset", 64'(rspValid), 64'(0));
    chk("R11 memReq after reset", 64'(memReqValid), 64'(0));
    xlate("R11 empty cache walks", 32'h0000_00F3, 1'b0, 5, 1);
  endtask

  task automatic test_walk;
    int lat;
    logic [29:0] pa;
    logic [1:0] flt;
    runReq(32'h0000_30F3, 1'b0, lat, pa, flt);
    chk("R1 example address", 64'(pa), 64'h020C30F3);
    chk("R2 entry address", 64'(lastAddr), 64'h0000_000C);
    chk("R6 miss latency", 64'(lat), 64'(5));
    xlate("R1 write walk", 32'h0000_4ABC, 1'b1, 5, 1);
  endtask

  task automatic test_hit;
    xlate("R5 hit read", 32'h0000_0123, 1'b0, 1, 0);
    xlate("R5 hit write", 32'h0000_3FFF, 1'b1, 1, 0);
  endtask

  task automatic test_absent;
    xlate("R3 absent page", 32'h0000_5010, 1'b0, 5, 1);
    xlate("R3 absent not cached", 32'h0000_5010, 1'b0, 5, 1);
  endtask

  task automatic test_prot;
    xlate("R4 write to read-only", 32'h0000_6004, 1'b1, 5, 1);
    xlate("R4 read-only cached, read hits", 32'h0000_6008, 1'b0, 1, 0);
    xlate("R4 write to read-only on hit", 32'h0000_600C, 1'b1, 1, 0);
    xlate("R4 read without read right", 32'h0000_7000, 1'b0, 5, 1);
  endtask

  task automatic test_flush;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    xlate("R8 flushed page walks", 32'h0000_0200, 1'b0, 5, 1);
    xlate("R8 refilled page hits", 32'h0000_0204, 1'b0, 1, 0);
  endtask

  task automatic test_base;
    @(negedge clk);
    baseWrEn = 1'b1;
    baseWrData = 32'h0000_0200;
    @(negedge clk);
    baseWrEn = 1'b0;
    curBase = 32'h0000_0200;
    xlate("R7 new table walks", 32'h0000_0200, 1'b0, 5, 1);
    chk("R7 R2 entry address in new table", 64'(lastAddr), 64'h0000_0200);
    xlate("R7 new table page 1", 32'h0000_1040, 1'b0, 5, 1);
    chk("R2 entry address page 1", 64'(lastAddr), 64'h0000_0204);
  endtask

  task automatic test_rr;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int v = 8; v < 16; v++) xlate("R9 fill", 32'(v) << 12, 1'b0, 5, 1);
    for (int v = 8; v < 16; v++) xlate("R9 all eight hit", (32'(v) << 12) | 32'h10, 1'b0, 1, 0);
    xlate("R9 ninth page fills", 32'h0001_0000, 1'b0, 5, 1);
    xlate("R9 survivor hits", 32'h0000_9000, 1'b0, 1, 0);
    xlate("R9 oldest evicted", 32'h0000_8000, 1'b0, 5, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      ptMem[i]       = {3'b111, 11'd0, 18'h020C0 + 18'(i)};
      ptMem[128 + i] = {3'b111, 11'd0, 18'h03000 + 18'(i)};
    end
    ptMem[5] = 32'h0000_0000;
    ptMem[6] = {3'b110, 11'd0, 18'h00066};
    ptMem[7] = {3'b101, 11'd0, 18'h00077};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset;
    test_walk;
    test_hit;
    test_absent;
    test_prot;
    test_flush;
    test_base;
    test_rr;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule